// File: doc/BRIEF.md
# Per-Pixel Error-Accumulation Dimmer

This block lets a display whose pixels can only be on or off show intermediate brightness. Every pixel owns a small running accumulator. Each time a brightness level for that pixel arrives, the level is added to the accumulator. The carry out of that addition is the pixel's on/off bit for the frame, and the wrapped sum is stored back. Over many frames the fraction of lit frames tracks the level. The accumulator holds the error between what has been shown and what was asked for.

After reset the block spends one clock per pixel writing a pseudo-random starting value into every accumulator. Because of this, pixels that request the same level get the same duty cycle but do not switch on and off together. Levels then stream in at up to one pixel per clock. A frame-start qualifier on a beat marks pixel 0, and every later beat takes the next pixel index. Each result leaves the block two clock edges later, tagged with its pixel index and a valid strobe, ready for a scan engine to shift out.

Top module: `pixel_dither`

## Requirements
- R1: While `rst` is high, and for exactly NPIX clock edges after it is released, `busy` is 1 and `out_valid` is 0. After that, `busy` stays 0 until the next reset.
- R2: During that sweep, pixel p starts with the low 8 bits of a 16-bit LFSR state taken after p advances. The sweep starts from the state 0xACE1, and each advance computes `next = {s[14:0], s[15]^s[13]^s[12]^s[10]}`. Pixel 0 therefore starts at 0xE1.
- R3: Beats presented while `busy` is 1 are dropped. They produce no output and change no accumulator.
- R4: A beat with `in_valid` and `frame_start` both high updates pixel 0. A beat with only `in_valid` high updates the pixel after the previous one, and pixel NPIX-1 wraps to pixel 0. The first plain beat after the sweep updates pixel 0.
- R5: For each accepted beat, the block forms the 9-bit sum of the stored 8-bit accumulator and `in_level`. `out_lit` is bit 8 of that sum, and the accumulator keeps bits 7..0.
- R6: An accepted beat sampled at clock edge n drives `out_valid`=1, `out_idx` and `out_lit` after edge n+2. `out_valid` is 0 in every cycle with no such beat.
- R7: Two consecutive beats that update the same pixel behave as if processed strictly in order. The second beat sees the accumulator value written by the first.
- R8: A level of 0 never lights a pixel, and it leaves that pixel's accumulator unchanged.
- R9: A pixel fed level 255 in 256 consecutive updates is lit in exactly 255 of them.
- R10: `frame_start` with `in_valid` low has no effect on pixel indexing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A brightness level is presented this cycle |
| frame_start | input | 1 | With in_valid: this beat is pixel 0 |
| in_level | input | LVL_W | Requested brightness, 0 to 255 |
| busy | output | 1 | Seeding sweep in progress; input is ignored |
| out_valid | output | 1 | out_idx and out_lit carry a result |
| out_idx | output | IDX_W | Pixel index of the result |
| out_lit | output | 1 | Pixel on (1) or off (0) for this frame |

## Verification
Several rules are checked by assertions on every clock:
- output stays silent while the sweep runs, and the sweep never restarts;
- each accepted beat yields a result two edges later;
- a frame-start beat reports pixel 0;
- a zero level is never lit;
- every reported index is in range;
- the seeding LFSR never locks up at zero.

Only the bench's reference model can show the rest:
- the exact seed values;
- the carry sequence across many frames;
- correct results when the same pixel is updated on back-to-back beats;
- the 255-of-256 duty for full brightness;
- that dropped beats and stray frame-start pulses leave no trace in later results.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // maximal-length polynomial x^16 + x^14 + x^13 + x^11 + 1
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pd_lfsr.sv
module pd_lfsr
  import pd_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = LFSR_SEED
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [LFSR_W-1:0] state
);
  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= lfsr_next(state);
  end

  // R2
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/pd_acc_ram.sv
module pd_acc_ram #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read-first: a read and a write to one address in the same cycle returns the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pixel_dither.sv
module pixel_dither
  import pd_pkg::*;
#(
  parameter int NPIX  = 64,
  parameter int LVL_W = 8,
  parameter int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             frame_start,
  input  logic [LVL_W-1:0] in_level,
  output logic             busy,
  output logic             out_valid,
  output logic [IDX_W-1:0] out_idx,
  output logic             out_lit
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic [IDX_W-1:0]  init_idx, last_idx, rd_idx;
  logic              accept;
  logic [LFSR_W-1:0] lfsr_q;

  // stage 1: level waits for the accumulator read
  logic              s1_valid;
  logic [IDX_W-1:0]  s1_idx;
  logic [LVL_W-1:0]  s1_lvl;
  logic [LVL_W-1:0]  ram_q, acc_cur;
  logic [LVL_W:0]    sum;

  // copy of the last write, for a back-to-back hit on one pixel
  logic              fwd_valid;
  logic [IDX_W-1:0]  fwd_idx;
  logic [LVL_W-1:0]  fwd_acc;

  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [LVL_W-1:0]  ram_wdata;

  assign accept = in_valid && !busy;
  assign rd_idx = frame_start ? '0 : ((last_idx == LAST) ? '0 : last_idx + 1'b1);

  pd_lfsr u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .adv   (busy),
    .state (lfsr_q)
  );

  always_comb begin
    acc_cur = (fwd_valid && fwd_idx == s1_idx) ? fwd_acc : ram_q;
    sum     = {1'b0, acc_cur} + {1'b0, s1_lvl};
  end

  always_comb begin
    ram_we    = busy || s1_valid;
    ram_waddr = busy ? init_idx : s1_idx;
    ram_wdata = busy ? lfsr_q[LVL_W-1:0] : sum[LVL_W-1:0];
  end

  pd_acc_ram #(.DEPTH(NPIX), .DW(LVL_W), .AW(IDX_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (rd_idx),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b1;
      init_idx  <= '0;
      last_idx  <= LAST;
      s1_valid  <= 1'b0;
      s1_idx    <= '0;
      s1_lvl    <= '0;
      fwd_valid <= 1'b0;
      fwd_idx   <= '0;
      fwd_acc   <= '0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_lit   <= 1'b0;
    end else begin
      if (busy) begin
        init_idx <= init_idx + 1'b1;
        if (init_idx == LAST) busy <= 1'b0;
      end
      if (accept) last_idx <= rd_idx;
      s1_valid  <= accept;
      s1_idx    <= rd_idx;
      s1_lvl    <= in_level;
      fwd_valid <= s1_valid;
      fwd_idx   <= s1_idx;
      fwd_acc   <= sum[LVL_W-1:0];
      out_valid <= s1_valid;
      out_idx   <= s1_idx;
      out_lit   <= s1_valid && sum[LVL_W];
    end
  end

  // R1
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !out_valid);
  // R1
  busy_once_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !busy);
  // R3
  drop_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && busy) |=> ##1 !out_valid);
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> ##1 out_valid);
  // R4
  start_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && frame_start) |=> ##1 (out_idx == '0));
  // R8
  dark_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_level == '0) |=> ##1 !out_lit);
  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx <= LAST));
endmodule

// File: tb/sim_pixel_dither.sv
module sim_pixel_dither;
  localparam int NPIX  = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic frame_start = 1'b0;
  logic [7:0] in_level = '0;
  logic busy, out_valid, out_lit;
  logic [IDX_W-1:0] out_idx;

  always #5 clk = ~clk;

  pixel_dither #(.NPIX(NPIX), .LVL_W(8)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .frame_start(frame_start),
    .in_level(in_level), .busy(busy), .out_valid(out_valid),
    .out_idx(out_idx), .out_lit(out_lit)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // reference state
  int acc [NPIX];
  int lfsr_m, sweep_n, last_m;
  bit pv; int pidx; bit plit; int plvl; string ptag = "R6";
  int cnt255, lit255;

  function automatic int lfsr_adv(input int s);
    int fb;
    fb = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | fb) & 16'hFFFF;
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit v, input bit fs, input int lvl, input string tag);
    bit nv; int nidx; bit nlit; int s;
    in_valid = v; frame_start = fs; in_level = 8'(lvl);
    nv = 0; nidx = 0; nlit = 0;
    if (rst) begin
      sweep_n = 0; lfsr_m = 16'hACE1; last_m = NPIX - 1;
    end else if (sweep_n < NPIX) begin
      acc[sweep_n] = lfsr_m & 255;       // R2 seeding
      lfsr_m = lfsr_adv(lfsr_m);
      sweep_n++;                          // R3: beat dropped
    end else if (v) begin
      nidx = fs ? 0 : (last_m + 1) % NPIX; // R4
      last_m = nidx;
      s = acc[nidx] + lvl;                  // R5
      nlit = s > 255;
      acc[nidx] = s & 255;
      nv = 1;
    end
    @(negedge clk);
    check("R1", busy, (rst || sweep_n < NPIX) ? 1 : 0, "busy");
    check(pv ? ptag : "R6", out_valid, pv, "out_valid");
    if (pv) begin
      check(ptag, out_idx, pidx, "out_idx");
      check(ptag, out_lit, plit, "out_lit");
      if (plvl == 255 && pidx == 3) begin
        cnt255++;
        if (out_lit) lit255++;
      end
    end
    pv = nv; pidx = nidx; plit = nlit; plvl = lvl; ptag = tag;
  endtask

  task automatic frame(input int lvl_mode, input bit gaps, input string tag);
    for (int p = 0; p < NPIX; p++) begin
      int l;
      l = (lvl_mode < 0) ? int'($urandom_range(255)) : lvl_mode;
      if (gaps && $urandom_range(2) == 0) step(0, 0, 0, tag);
      step(1, p == 0, l, tag);
    end
  endtask

  initial begin
    pv = 0;
    // R1: reset holds busy
    repeat (3) step(0, 0, 0, "R1");
    rst = 1'b0;
    // R3: beats during the sweep are dropped; R2 seeds then checked via results
    for (int i = 0; i < NPIX; i++) step(1, i % 3 == 0, 200, "R3");
    step(0, 0, 0, "R1");
    // R4 + R2: plain beats start at pixel 0, seed values show in first carries
    for (int i = 0; i < 5; i++) step(1, 0, 128, "R2");
    // R10: stray frame_start without in_valid
    step(0, 1, 0, "R10");
    step(1, 0, 90, "R10");  // pixel 5
    // R4: wrap past last pixel
    for (int i = 0; i < NPIX + 3; i++) step(1, 0, 77, "R4");
    // R5: random frames, with and without gaps (R6)
    for (int f = 0; f < 20; f++) frame(-1, 0, "R5");
    for (int f = 0; f < 10; f++) frame(-1, 1, "R6");
    // R7: back-to-back updates of pixel 0
    for (int i = 0; i < 12; i++) step(1, 1, int'($urandom_range(255)), "R7");
    step(0, 0, 0, "R7");
    step(1, 1, 200, "R7"); step(0, 0, 0, "R7"); step(1, 1, 200, "R7");
    // R8: zero level, then random frames confirm accumulators untouched
    for (int f = 0; f < 10; f++) frame(0, 0, "R8");
    for (int f = 0; f < 3; f++) frame(-1, 0, "R8");
    // R9: full brightness for 256 frames
    cnt255 = 0; lit255 = 0;
    for (int f = 0; f < 256; f++) frame(255, 0, "R9");
    step(0, 0, 0, "R9"); step(0, 0, 0, "R9");
    check("R9", cnt255, 256, "updates at 255");
    check("R9", lit255, 255, "lit frames at 255");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule